// File: doc/BRIEF.md
# Active fuzzy set pair selector

This block sits at the front of a two-input fuzzy controller. Each 8-bit input is covered by seven fuzzy sets, numbered 0 to 6 from the lowest, and neighbouring sets overlap so that any input value lies inside at most two of them. For each input, the block works out which adjacent pair of sets is live. It also reports, for each set of that pair, whether the input sits on the set's rising side or on its falling side. With two inputs this cuts the rule base from 49 combinations down to the four rules that can contribute, and the rule address generator that follows only has to walk those four.

Set 0 and set 1 always form the starting pair. The pair slides one set to the right each time the input reaches the rise start point of a set beyond the current pair, beginning with set 2. An input equal to a rise start point already counts as reached. Every pair contains one odd-numbered set and one even-numbered set, and the two are reported on separate outputs. This lets downstream logic keep odd and even rule streams apart. The rise start and fall start points of each input are constant parameter tables in ascending order. The selection is purely combinational, and the two inputs never affect each other.

Top module: `fz_ars_top`

## Requirements
- R1: For each input, the odd index output is odd and lies in 1..5, the even index output is even and lies in 0..6, and the two indices differ by exactly one.
- R2: While an input is below the rise start point of set 2, its pair is sets 0 and 1 (even index 0, odd index 1), whatever the rise start points of sets 0 and 1 are.
- R3: The lower set of the pair equals the number of sets j in 2..6 whose rise start point is less than or equal to the input, so an input equal to a rise start point already moves the pair.
- R4: The region bit of a set in the pair (0 to 5) is 1 when the input is greater than or equal to that set's fall start point, and 0 when the input is below it.
- R5: Set 6 has no fall start point, so its region bit is 0 for every input.
- R6: Each input's indices and region bits depend only on that input and its own tables; changing the other input leaves them unchanged.
- R7: An input at or above the rise start point of set 6 selects the pair of sets 5 and 6 (odd index 5, even index 6).
- R8: The outputs follow the inputs with no clock: a new input value gives its new outputs within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in0 | input | 8 | Crisp value of input 0 |
| in1 | input | 8 | Crisp value of input 1 |
| odd_idx0 | output | 3 | Odd-numbered set of the active pair of input 0 |
| even_idx0 | output | 3 | Even-numbered set of the active pair of input 0 |
| odd_reg0 | output | 1 | Region of the odd set of input 0 (0 rising, 1 falling) |
| even_reg0 | output | 1 | Region of the even set of input 0 (0 rising, 1 falling) |
| odd_idx1 | output | 3 | Odd-numbered set of the active pair of input 1 |
| even_idx1 | output | 3 | Even-numbered set of the active pair of input 1 |
| odd_reg1 | output | 1 | Region of the odd set of input 1 (0 rising, 1 falling) |
| even_reg1 | output | 1 | Region of the even set of input 1 (0 rising, 1 falling) |

## Verification
Each rise start point is driven exactly and one below. This separates a move on equality from a move only on strictly greater, and it catches a comparison made against the wrong set. Each fall start point is probed the same way to pin down the region boundary. The top of the range is probed to show that set 6 never reports a falling region. One input is held while the other is swept, which exposes any coupling between the two channels. A full sweep of all 256 values on both inputs then compares against a model, and this also covers the order in which the odd and even indices alternate as the pair moves.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_SETS = 7;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned N_CH   = 2;
endpackage

// File: rtl/fz_pair_sel.sv
module fz_pair_sel #(
  parameter int unsigned W      = fz_pkg::DATA_W,
  parameter int unsigned NSETS  = fz_pkg::N_SETS,
  parameter int unsigned IDXW   = fz_pkg::IDX_W,
  parameter logic [NSETS*W-1:0] RISE_TBL = '0
) (
  input  logic [W-1:0]    val,
  output logic [IDXW-1:0] base
);
  localparam int unsigned FIRST_CMP = 2;

  logic [NSETS-1:0] reached;

  assign reached[FIRST_CMP-1:0] = '0;

  for (genvar j = FIRST_CMP; j < NSETS; j++) begin : g_cmp
    logic [W:0] diff;
    assign diff       = {1'b0, val} - {1'b0, RISE_TBL[j*W +: W]};
    assign reached[j] = ~diff[W];
  end

  always_comb begin
    base = '0;
    for (int j = FIRST_CMP; j < NSETS; j++) begin
      base = base + IDXW'(reached[j]);
    end
  end
endmodule

// File: rtl/fz_region.sv
module fz_region #(
  parameter int unsigned W      = fz_pkg::DATA_W,
  parameter int unsigned NSETS  = fz_pkg::N_SETS,
  parameter int unsigned IDXW   = fz_pkg::IDX_W,
  parameter logic [NSETS*W-1:0] FALL_TBL = '0
) (
  input  logic [W-1:0]    val,
  input  logic [IDXW-1:0] set_a,
  input  logic [IDXW-1:0] set_b,
  output logic            reg_a,
  output logic            reg_b
);
  localparam int unsigned NSLOT = 1 << IDXW;

  logic [NSLOT-1:0] past_fall;

  for (genvar j = 0; j < NSLOT; j++) begin : g_fall
    if (j < NSETS - 1) begin : g_live
      assign past_fall[j] = (val >= FALL_TBL[j*W +: W]);
    end else begin : g_none
      assign past_fall[j] = 1'b0;
    end
  end

  assign reg_a = past_fall[set_a];
  assign reg_b = past_fall[set_b];
endmodule

// File: rtl/fz_ars_top.sv
module fz_ars_top #(
  parameter int unsigned W     = fz_pkg::DATA_W,
  parameter int unsigned NSETS = fz_pkg::N_SETS,
  parameter int unsigned IDXW  = fz_pkg::IDX_W,
  parameter logic [NSETS*W-1:0] RISE0 = {8'd220, 8'd180, 8'd140, 8'd100, 8'd60, 8'd30, 8'd0},
  parameter logic [NSETS*W-1:0] FALL0 = {8'd255, 8'd235, 8'd195, 8'd155, 8'd115, 8'd75, 8'd40},
  parameter logic [NSETS*W-1:0] RISE1 = {8'd200, 8'd160, 8'd120, 8'd80, 8'd50, 8'd20, 8'd0},
  parameter logic [NSETS*W-1:0] FALL1 = {8'd255, 8'd215, 8'd175, 8'd135, 8'd95, 8'd60, 8'd25}
) (
  input  logic [W-1:0]    in0,
  input  logic [W-1:0]    in1,
  output logic [IDXW-1:0] odd_idx0,
  output logic [IDXW-1:0] even_idx0,
  output logic            odd_reg0,
  output logic            even_reg0,
  output logic [IDXW-1:0] odd_idx1,
  output logic [IDXW-1:0] even_idx1,
  output logic            odd_reg1,
  output logic            even_reg1
);
  localparam int unsigned NCH = fz_pkg::N_CH;

  logic [W-1:0]    ch_in   [NCH];
  logic [IDXW-1:0] ch_odd  [NCH];
  logic [IDXW-1:0] ch_even [NCH];
  logic            ch_ro   [NCH];
  logic            ch_re   [NCH];

  assign ch_in[0] = in0;
  assign ch_in[1] = in1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [NSETS*W-1:0] RT = (c == 0) ? RISE0 : RISE1;
    localparam logic [NSETS*W-1:0] FT = (c == 0) ? FALL0 : FALL1;

    logic [IDXW-1:0] base;
    logic [IDXW-1:0] upper;

    fz_pair_sel #(.W(W), .NSETS(NSETS), .IDXW(IDXW), .RISE_TBL(RT)) u_sel (
      .val  (ch_in[c]),
      .base (base)
    );

    assign upper = base + IDXW'(1);

    always_comb begin
      if (base[0]) begin
        ch_odd[c]  = base;
        ch_even[c] = upper;
      end else begin
        ch_odd[c]  = upper;
        ch_even[c] = base;
      end
    end

    fz_region #(.W(W), .NSETS(NSETS), .IDXW(IDXW), .FALL_TBL(FT)) u_reg (
      .val   (ch_in[c]),
      .set_a (ch_odd[c]),
      .set_b (ch_even[c]),
      .reg_a (ch_ro[c]),
      .reg_b (ch_re[c])
    );
  end

  assign odd_idx0  = ch_odd[0];
  assign even_idx0 = ch_even[0];
  assign odd_reg0  = ch_ro[0];
  assign even_reg0 = ch_re[0];
  assign odd_idx1  = ch_odd[1];
  assign even_idx1 = ch_even[1];
  assign odd_reg1  = ch_ro[1];
  assign even_reg1 = ch_re[1];
endmodule

// File: rtl/fz_ars_chk.sv
module fz_ars_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned NSETS = 7,
  parameter int unsigned IDXW  = 3,
  parameter logic [NSETS*W-1:0] RISE0 = '0,
  parameter logic [NSETS*W-1:0] RISE1 = '0
) (
  input logic [W-1:0]    in0,
  input logic [W-1:0]    in1,
  input logic [IDXW-1:0] odd_idx0,
  input logic [IDXW-1:0] even_idx0,
  input logic            even_reg0,
  input logic [IDXW-1:0] odd_idx1,
  input logic [IDXW-1:0] even_idx1,
  input logic            even_reg1
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NSETS - 1);

  always_comb begin
    p_odd_parity_r1: assert (odd_idx0[0] && odd_idx1[0])
      else $error("odd index not odd");
    p_even_parity_r1: assert (!even_idx0[0] && !even_idx1[0])
      else $error("even index not even");
    p_adjacent_r1: assert (((odd_idx0 - even_idx0 == 1) || (even_idx0 - odd_idx0 == 1)) &&
                           ((odd_idx1 - even_idx1 == 1) || (even_idx1 - odd_idx1 == 1)))
      else $error("pair not adjacent");
    p_in_range_r1: assert (even_idx0 <= LAST && even_idx1 <= LAST)
      else $error("index out of range");
    p_first_pair_r2: assert (!(in0 < RISE0[2*W +: W]) || (even_idx0 == 0 && odd_idx0 == 1))
      else $error("input 0 low pair wrong");
    p_first_pair1_r2: assert (!(in1 < RISE1[2*W +: W]) || (even_idx1 == 0 && odd_idx1 == 1))
      else $error("input 1 low pair wrong");
    p_last_region_r5: assert (!(even_idx0 == LAST && even_reg0) && !(even_idx1 == LAST && even_reg1))
      else $error("last set reports falling region");
    p_top_pair_r7: assert (!(in0 >= RISE0[(NSETS-1)*W +: W]) || (even_idx0 == LAST))
      else $error("input 0 top pair wrong");
  end
endmodule

bind fz_ars_top fz_ars_chk #(
  .W(W), .NSETS(NSETS), .IDXW(IDXW), .RISE0(RISE0), .RISE1(RISE1)
) u_chk (
  .in0(in0), .in1(in1),
  .odd_idx0(odd_idx0), .even_idx0(even_idx0), .even_reg0(even_reg0),
  .odd_idx1(odd_idx1), .even_idx1(even_idx1), .even_reg1(even_reg1)
);

// File: tb/tb_fz_ars_top.sv
`timescale 1ns/1ps
module tb_fz_ars_top;
  localparam int W = 8;
  localparam int NSETS = 7;
  localparam logic [NSETS*W-1:0] R0 = {8'd220, 8'd180, 8'd140, 8'd100, 8'd60, 8'd30, 8'd0};
  localparam logic [NSETS*W-1:0] F0 = {8'd255, 8'd235, 8'd195, 8'd155, 8'd115, 8'd75, 8'd40};
  localparam logic [NSETS*W-1:0] R1 = {8'd200, 8'd160, 8'd120, 8'd80, 8'd50, 8'd20, 8'd0};
  localparam logic [NSETS*W-1:0] F1 = {8'd255, 8'd215, 8'd175, 8'd135, 8'd95, 8'd60, 8'd25};

  logic clk;
  logic rst_n;
  logic [7:0] in0, in1;
  logic [2:0] odd_idx0, even_idx0, odd_idx1, even_idx1;
  logic odd_reg0, even_reg0, odd_reg1, even_reg1;
  int checks, errors;
  bit done;

  fz_ars_top #(.RISE0(R0), .FALL0(F0), .RISE1(R1), .FALL1(F1)) dut (
    .in0(in0), .in1(in1),
    .odd_idx0(odd_idx0), .even_idx0(even_idx0), .odd_reg0(odd_reg0), .even_reg0(even_reg0),
    .odd_idx1(odd_idx1), .even_idx1(even_idx1), .odd_reg1(odd_reg1), .even_reg1(even_reg1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int rise_of(int ch, int s);
    return (ch == 0) ? int'(R0[s*W +: W]) : int'(R1[s*W +: W]);
  endfunction

  function automatic int fall_of(int ch, int s);
    return (ch == 0) ? int'(F0[s*W +: W]) : int'(F1[s*W +: W]);
  endfunction

  // Expected {odd, even, odd_reg, even_reg} per R1, R3, R4, R5
  function automatic logic [7:0] expect_of(int ch, int v);
    int lo, od, ev, ro, re;
    lo = 0;
    for (int j = 2; j < NSETS; j++) if (v >= rise_of(ch, j)) lo++;
    od = (lo % 2 == 1) ? lo : lo + 1;
    ev = (lo % 2 == 0) ? lo : lo + 1;
    ro = (v >= fall_of(ch, od)) ? 1 : 0;
    re = (ev == NSETS - 1) ? 0 : ((v >= fall_of(ch, ev)) ? 1 : 0);
    return {od[2:0], ev[2:0], ro[0], re[0]};
  endfunction

  task automatic drive(int a, int b);
    @(negedge clk);
    in0 = a[7:0];
    in1 = b[7:0];
    #1;
  endtask

  task automatic check_ch(int ch, string tag);
    logic [7:0] got, exp;
    int v;
    v   = (ch == 0) ? int'(in0) : int'(in1);
    got = (ch == 0) ? {odd_idx0, even_idx0, odd_reg0, even_reg0}
                    : {odd_idx1, even_idx1, odd_reg1, even_reg1};
    exp = expect_of(ch, v);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s in%0d=%0d got odd=%0d even=%0d ro=%0d re=%0d exp odd=%0d even=%0d ro=%0d re=%0d",
               tag, ch, v, got[7:5], got[4:2], got[1], got[0], exp[7:5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic check_val(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, act, expv);
    end
  endtask

  task automatic t_start_r2;
    drive(0, 0);
    check_val("R2 in0=0 even", int'(even_idx0), 0);
    check_val("R2 in0=0 odd", int'(odd_idx0), 1);
    check_val("R2 in1=0 odd", int'(odd_idx1), 1);
    drive(59, 49);
    check_val("R2 in0=59 even", int'(even_idx0), 0);
    check_val("R2 in1=49 odd", int'(odd_idx1), 1);
  endtask

  task automatic t_rise_edges_r3;
    for (int j = 2; j < NSETS; j++) begin
      drive(rise_of(0, j) - 1, rise_of(1, j) - 1);
      check_ch(0, "R3 below rise");
      check_ch(1, "R3 below rise");
      drive(rise_of(0, j), rise_of(1, j));
      check_ch(0, "R3 on rise");
      check_ch(1, "R3 on rise");
    end
    drive(60, 50);
    check_val("R3 in0=60 even", int'(even_idx0), 2);
    check_val("R3 in0=60 odd", int'(odd_idx0), 1);
    check_val("R3 in1=50 even", int'(even_idx1), 2);
  endtask

  task automatic t_fall_edges_r4;
    for (int j = 0; j < NSETS - 1; j++) begin
      drive(fall_of(0, j) - 1, fall_of(1, j) - 1);
      check_ch(0, "R4 below fall");
      check_ch(1, "R4 below fall");
      drive(fall_of(0, j), fall_of(1, j));
      check_ch(0, "R4 on fall");
      check_ch(1, "R4 on fall");
    end
    drive(45, 0);
    check_val("R4 in0=45 even_reg", int'(even_reg0), 1);
    check_val("R4 in0=45 odd_reg", int'(odd_reg0), 0);
  endtask

  task automatic t_top_r5_r7;
    drive(255, 255);
    check_val("R7 in0=255 odd", int'(odd_idx0), 5);
    check_val("R7 in0=255 even", int'(even_idx0), 6);
    check_val("R5 in0=255 even_reg", int'(even_reg0), 0);
    check_val("R4 in0=255 odd_reg", int'(odd_reg0), 1);
    check_val("R5 in1=255 even_reg", int'(even_reg1), 0);
    drive(220, 200);
    check_val("R7 in0=220 even", int'(even_idx0), 6);
    check_val("R7 in1=200 even", int'(even_idx1), 6);
  endtask

  task automatic t_indep_r6;
    logic [7:0] held;
    drive(100, 0);
    held = {odd_idx0, even_idx0, odd_reg0, even_reg0};
    for (int b = 0; b < 256; b += 17) begin
      drive(100, b);
      check_val("R6 in0 unchanged by in1", int'({odd_idx0, even_idx0, odd_reg0, even_reg0}), int'(held));
      check_ch(1, "R6 in1 own");
    end
  endtask

  task automatic t_comb_r8;
    @(negedge clk);
    in0 = 8'd150;
    in1 = 8'd10;
    #1;
    check_ch(0, "R8 same step");
    in0 = 8'd10;
    #1;
    check_ch(0, "R8 same step");
  endtask

  task automatic t_sweep_r1;
    for (int v = 0; v < 256; v++) begin
      drive(v, 255 - v);
      check_ch(0, "R1 sweep");
      check_ch(1, "R1 sweep");
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    in0 = 8'd0;
    in1 = 8'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_start_r2();
    t_rise_edges_r3();
    t_fall_edges_r4();
    t_top_r5_r7();
    t_indep_r6();
    t_comb_r8();
    t_sweep_r1();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule